// File: doc/BRIEF.md
# Strobed Switch-State Monitor

This block watches eight switch channels, each seen through a digital comparator input. An external strobe pin controls the sampling. While the strobe is high, every enabled channel that is set to follow the strobe has its excitation output turned on. When the strobe falls, that channel's comparator level is latched as the new switch state. An enabled channel that is not set to follow the strobe keeps its excitation on all the time and samples on every clock. Whenever a new sample differs from the stored state, the channel's sticky change flag is set.

The flags drive an active-low interrupt, masked per channel. While the low-power input is asserted, the flags of enabled channels also drive a wake request. Clearing a channel's enable bit removes that channel from sampling and from waking, which shuts out a stuck switch or a shorted line. Software configures the block and reads it back through a small register port with single-cycle writes and combinational reads. The strobe pin and the comparator pins each pass through a two-flop synchronizer inside the block. An undriven strobe is expected to sit low, and a low strobe never samples.

Top module: `strobe_switch_monitor`

## Requirements
- R1: After reset, the enable, mode, interrupt-enable, flag and state registers all read zero. `exc_en` is zero, `irq_n` is 1 and `wake_req` is 0.
- R2: An enabled channel whose mode bit is 1 drives `exc_en` high exactly while the synchronized strobe is high. An enabled channel whose mode bit is 0 drives `exc_en` high constantly. A disabled channel drives it low.
- R3: An enabled channel whose mode bit is 1 loads its comparator level into its state bit only on a falling strobe edge. A rising edge and a high strobe level leave the state unchanged.
- R4: An enabled channel whose mode bit is 0 loads its synchronized comparator level into its state bit on every clock.
- R5: Whenever a channel loads a level that differs from its stored state bit, its change flag (register 3, bit i for channel i) is set.
- R6: A change flag stays set until a register-3 write with a 1 in that bit. Writing 0 to a bit leaves that flag unchanged.
- R7: `irq_n` is 0 exactly when some channel has both its flag and its interrupt-enable bit (register 2) set.
- R8: A channel whose enable bit (register 0) is 0 does not sample. Its state bit and its flag do not change.
- R9: `wake_req` is 1 exactly when `low_power` is 1 and some channel has both its flag and its enable bit set. Clearing the enable bit withdraws that channel's wake even though its flag stays set.
- R10: The register map is: address 0 is channel enable, 1 is strobe mode, 2 is interrupt enable, 3 is flags, and 4 is the read-only latched state. Addresses 0 to 2 read back the value last written. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_power | input | 1 | Low-power mode indication; gates wake_req |
| strobe_in | input | 1 | Shared asynchronous sampling strobe |
| cmp_in | input | 8 | Asynchronous comparator level per channel |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| exc_en | output | 8 | Excitation enable per channel |
| irq_n | output | 1 | Active-low interrupt |
| wake_req | output | 1 | Wake request while in low-power mode |

## Verification
Each of the 256 comparator patterns is latched in turn through a full strobe pulse. For each pulse, the comparator is first held at the complement of the target pattern across the rising edge, which separates latching at the falling edge from latching at the rising edge. Each pattern also rotates the interrupt-enable mask, so the flags and the interrupt are checked against an independent XOR of the old and new states. A second sweep over sixteen enable masks separates masked sampling from blind sampling. Separate sequences toggle a channel in free-running mode and move the low-power and enable inputs around set flags, which shows that wake follows the enable bits rather than the interrupt mask.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_EN    = 3'd0,
    REG_MODE  = 3'd1,
    REG_IEN   = 3'd2,
    REG_FLAG  = 3'd3,
    REG_STATE = 3'd4
  } reg_sel_e;

  // excitation: strobe-following channels are on only while strobe is high
  function automatic logic exc_level(logic en, logic strobed, logic strobe_hi);
    return en & (~strobed | strobe_hi);
  endfunction

  // sampling: strobe-following channels sample on the falling edge only
  function automatic logic take_sample(logic en, logic strobed, logic fall);
    return en & (~strobed | fall);
  endfunction
endpackage

// File: rtl/ssm_sync.sv
module ssm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ssm_fall_det.sv
module ssm_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign fall = prev & ~lvl;
endmodule

// File: rtl/ssm_channel.sv
module ssm_channel
  import ssm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic strobed,
  input  logic strobe_hi,
  input  logic fall,
  input  logic cmp,
  input  logic clr,
  output logic state,
  output logic flag,
  output logic exc
);
  logic sample_evt;
  logic diff_evt;

  assign sample_evt = take_sample(en, strobed, fall);
  assign diff_evt   = sample_evt & (cmp != state);
  assign exc        = exc_level(en, strobed, strobe_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          state <= 1'b0;
    else if (sample_evt) state <= cmp;
  end

  // a new change wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (diff_evt) flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(state) && !$rose(flag));                      // R8
  AST_NO_SAMPLE_WITHOUT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && strobed && !fall) |=> $stable(state));                 // R3
  AST_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && (cmp != state)) |=> flag);                     // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);                                     // R6
endmodule

// File: rtl/ssm_regs.sv
module ssm_regs
  import ssm_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [NUM_CH-1:0] cfg_wdata,
  input  logic [NUM_CH-1:0] flags,
  input  logic [NUM_CH-1:0] states,
  output logic [NUM_CH-1:0] en,
  output logic [NUM_CH-1:0] mode,
  output logic [NUM_CH-1:0] ien,
  output logic [NUM_CH-1:0] clr,
  output logic [NUM_CH-1:0] cfg_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      mode <= '0;
      ien  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        REG_EN:   en   <= cfg_wdata;
        REG_MODE: mode <= cfg_wdata;
        REG_IEN:  ien  <= cfg_wdata;
        default:  ;
      endcase
    end
  end

  assign clr = (cfg_we && cfg_addr == REG_FLAG) ? cfg_wdata : '0;

  always_comb begin
    case (cfg_addr)
      REG_EN:    cfg_rdata = en;
      REG_MODE:  cfg_rdata = mode;
      REG_IEN:   cfg_rdata = ien;
      REG_FLAG:  cfg_rdata = flags;
      REG_STATE: cfg_rdata = states;
      default:   cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/strobe_switch_monitor.sv
module strobe_switch_monitor
  import ssm_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              low_power,
  input  logic              strobe_in,
  input  logic [NUM_CH-1:0] cmp_in,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [NUM_CH-1:0] cfg_wdata,
  output logic [NUM_CH-1:0] cfg_rdata,
  output logic [NUM_CH-1:0] exc_en,
  output logic              irq_n,
  output logic              wake_req
);
  logic              strobe_hi;
  logic              strobe_fall;
  logic [NUM_CH-1:0] cmp_s;
  logic [NUM_CH-1:0] en, mode, ien, clr;
  logic [NUM_CH-1:0] flags, states;

  ssm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_strobe_sync (
    .clk(clk), .rst_n(rst_n), .d(strobe_in), .q(strobe_hi));

  ssm_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_cmp_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_in), .q(cmp_s));

  ssm_fall_det u_fall (
    .clk(clk), .rst_n(rst_n), .lvl(strobe_hi), .fall(strobe_fall));

  ssm_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .flags(flags), .states(states),
    .en(en), .mode(mode), .ien(ien), .clr(clr), .cfg_rdata(cfg_rdata));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ssm_channel u_ch (
      .clk(clk), .rst_n(rst_n), .en(en[i]), .strobed(mode[i]),
      .strobe_hi(strobe_hi), .fall(strobe_fall), .cmp(cmp_s[i]),
      .clr(clr[i]), .state(states[i]), .flag(flags[i]), .exc(exc_en[i]));
  end

  assign irq_n    = ~|(flags & ien);
  assign wake_req = low_power & |(flags & en);

  AST_WAKE_NEEDS_LP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> low_power);                                      // R9
  AST_NO_EXC_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en & ~en) == '0);                                        // R2
endmodule

// File: tb/sim_strobe_switch_monitor.sv
module sim_strobe_switch_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         rst_n = 1'b0, low_power = 1'b0, strobe_in = 1'b0, cfg_we = 1'b0;
  logic [N-1:0] cmp_in = '0, cfg_wdata = '0;
  logic [2:0]   cfg_addr = '0;
  logic [N-1:0] cfg_rdata, exc_en;
  logic         irq_n, wake_req;

  strobe_switch_monitor u0 (
    .clk(clk), .rst_n(rst_n), .low_power(low_power), .strobe_in(strobe_in),
    .cmp_in(cmp_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .exc_en(exc_en), .irq_n(irq_n), .wake_req(wake_req));

  int errors = 0;
  int checks = 0;
  logic [N-1:0] st_exp = '0;
  logic [N-1:0] fl_exp = '0;
  logic [N-1:0] v;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [N-1:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  // strobe pulse: cmp held at pre across the rise, pat across the fall
  task automatic pulse(logic [N-1:0] pre, logic [N-1:0] pat, logic [N-1:0] exc_exp);
    logic [N-1:0] r;
    @(negedge clk);
    cmp_in = pre; strobe_in = 1'b1;
    cyc(4);
    check("R2 exc while strobe high", exc_en, exc_exp);
    rd(3'd4, r);
    check("R3 no latch on rise/high", r, st_exp);
    cmp_in = pat;
    cyc(4);
    strobe_in = 1'b0;
    cyc(5);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], v);
      check("R1 register reset", v, 0);
    end
    check("R1 exc_en reset", exc_en, 0);
    check("R1 irq_n reset", irq_n, 1);
    check("R1 wake_req reset", wake_req, 0);

    // R10 readback and unused address
    wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'h96);
    rd(3'd0, v); check("R10 enable readback", v, 8'hA5);
    rd(3'd1, v); check("R10 mode readback", v, 8'h3C);
    rd(3'd2, v); check("R10 ien readback", v, 8'h96);
    rd(3'd6, v); check("R10 unused address", v, 0);

    // R8 disabled: no excitation
    wr(3'd0, 8'h00); wr(3'd1, 8'hFF);
    check("R2 disabled exc", exc_en, 0);

    // full sweep, all channels strobe-driven
    wr(3'd0, 8'hFF);
    check("R2 strobe low exc off", exc_en, 0);
    for (int p = 0; p < 256; p++) begin
      logic [N-1:0] pat, ie;
      pat = p[N-1:0];
      ie  = {pat[3:0], pat[7:4]} ^ 8'h0F;
      wr(3'd2, ie);
      pulse(~pat, pat, 8'hFF);
      fl_exp = fl_exp | (pat ^ st_exp);
      st_exp = pat;
      rd(3'd4, v); check("R3 latched state", v, st_exp);
      rd(3'd3, v); check("R5 change flags", v, fl_exp);
      check("R7 irq_n", irq_n, ((fl_exp & ie) == 0) ? 1 : 0);
      check("R2 exc after fall", exc_en, 0);
      wr(3'd3, 8'hFF);
      fl_exp = '0;
      rd(3'd3, v); check("R6 clear by write-1", v, 0);
    end

    // masked sweep
    for (int m = 0; m < 16; m++) begin
      logic [N-1:0] en, pat;
      en  = m[3:0] * 8'h11 ^ 8'h5A;
      pat = m[7:0] * 8'd37 + 8'd5;
      wr(3'd0, en);
      pulse(st_exp, pat, en);
      fl_exp = fl_exp | ((pat ^ st_exp) & en);
      st_exp = (pat & en) | (st_exp & ~en);
      rd(3'd4, v); check("R8 masked state", v, st_exp);
      rd(3'd3, v); check("R8 masked flags", v, fl_exp);
    end

    // R6 writing zero keeps flags
    wr(3'd3, 8'h00);
    rd(3'd3, v); check("R6 write-0 keeps flags", v, fl_exp);
    wr(3'd3, 8'hFF); fl_exp = '0;

    // R9 wake behaviour
    wr(3'd0, 8'hFF); wr(3'd2, 8'h00);
    low_power = 1'b1;
    cyc(1);
    check("R9 no wake without flag", wake_req, 0);
    pulse(st_exp, st_exp ^ 8'h21, 8'hFF);
    st_exp = st_exp ^ 8'h21; fl_exp = 8'h21;
    check("R9 wake on change", wake_req, 1);
    check("R7 irq masked", irq_n, 1);
    wr(3'd0, 8'hDE);
    check("R9 wake suppressed by enable", wake_req, 0);
    rd(3'd3, v); check("R9 flags kept", v, fl_exp);
    wr(3'd0, 8'h01);
    check("R9 wake via ch0", wake_req, 1);
    low_power = 1'b0;
    cyc(1);
    check("R9 no wake outside low power", wake_req, 0);
    wr(3'd3, 8'hFF); fl_exp = '0;

    // R4 continuous mode on channel 0
    wr(3'd0, 8'h01); wr(3'd1, 8'hFE);
    check("R2 continuous exc", exc_en, 8'h01);
    cmp_in = st_exp ^ 8'hFF;
    cyc(5);
    st_exp[0] = ~st_exp[0];
    rd(3'd4, v); check("R4 free-running sample", v, st_exp);
    rd(3'd3, v); check("R4 free-running flag", v, 8'h01);
    check("R8 others held", v & 8'hFE, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule